// File: doc/BRIEF.md
# Gated Edge Counter with Pause

This block counts the active edges of an asynchronous measured input and keeps the running total in a register that is always visible on `count_o`. Software-side configuration picks whether rising or falling transitions count, and a second asynchronous input serves as a pause control. The pause level is programmable: with `pause_pol_i` at 1 a high gate suspends counting, and with it at 0 a low gate does. Both asynchronous inputs cross into the system clock through two-flop synchronizers. Edges are found on the synchronized copies.

Counting stays idle until the block is armed by a one-cycle `start_i` pulse. A synchronous `clear_i` zeroes the count, drops any pending output beat and disarms the block, so a fresh `start_i` is needed. Every counted edge publishes the new count as a beat on a valid/ready output stream. While a beat waits for `out_ready_i`, its data holds steady. Edges counted in the meantime are not lost: the stream remembers that the count moved on. When the waiting beat is accepted, the next beat carries the latest count.

Top module: `gated_edge_counter`

## Requirements
- R1: After reset `count_o` is 0, `out_valid_o` is 0 and the block is not armed.
- R2: With `edge_sel_i` = 0, each 0-to-1 transition of `src_i` while armed and not paused raises `count_o` by exactly one, and 1-to-0 transitions do nothing.
- R3: With `edge_sel_i` = 1, each 1-to-0 transition of `src_i` while armed and not paused raises `count_o` by exactly one, and 0-to-1 transitions do nothing.
- R4: Before the first `start_i` pulse, and after a clear, source edges leave `count_o` unchanged and issue no beat. A `start_i` pulse arms counting.
- R5: Counting pauses while the synchronized gate equals `pause_pol_i`. During a pause, source edges leave `count_o` unchanged and issue no beat.
- R6: When a counted edge finds the output slot free (valid low, or ready high), the next cycle shows `out_valid_o` = 1 with `out_data_o` equal to the new count.
- R7: While `out_valid_o` = 1 and `out_ready_i` = 0, `out_data_o` and `out_valid_o` stay unchanged. Edges counted meanwhile set a pending mark, and the beat that follows acceptance carries the current `count_o`. With nothing pending, acceptance drops `out_valid_o` the next cycle.
- R8: The count is CNT_W bits wide and wraps from all ones to zero on the next counted edge.
- R9: `clear_i` forces `count_o` to 0 and `out_valid_o` to 0 in the next cycle and disarms the block. `clear_i` wins over a simultaneous `start_i`.
- R10: A level change on `src_i`, applied just after a clock edge, reaches `count_o` on the third rising clock edge that follows: two synchronizer stages and one count register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear; zeroes the count and disarms |
| start_i | input | 1 | One-cycle arm pulse |
| edge_sel_i | input | 1 | 0 counts rising edges, 1 counts falling edges |
| pause_pol_i | input | 1 | Gate level that pauses counting |
| src_i | input | 1 | Asynchronous measured signal |
| gate_i | input | 1 | Asynchronous pause gate |
| count_o | output | CNT_W | Running count |
| out_data_o | output | CNT_W | Count carried by the output beat |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Consumer accepts the beat |

## Verification
The assertions take two things for granted. First, `src_i` and `gate_i` hold each level for at least one clock, so the synchronized source shows clean single-cycle edge pulses. Second, the configuration inputs change only while no source edge is in flight, so the edge and pause decoding sees settled settings. The stimulus applies all inputs on the falling clock edge and holds every source level for four cycles. It changes `edge_sel_i`, `pause_pol_i` and `gate_i` only between source pulses, with the synchronizers already settled. A narrow 4-bit counter makes the wrap reachable within a short run.

// File: rtl/gec_pkg.sv
package gec_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/gec_sync.sv
module gec_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[LAST];
  end
endmodule

// File: rtl/gec_edge.sv
module gec_edge
  import gec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src_s_i,
  input  logic gate_s_i,
  input  logic edge_sel_i,
  input  logic pause_pol_i,
  output logic hit_o,
  output logic pause_o
);
  logic       src_prev_q;
  logic       rise, fall;
  edge_kind_e kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_prev_q <= 1'b0;
    else        src_prev_q <= src_s_i;
  end

  assign kind = edge_kind_e'(edge_sel_i);
  assign rise = src_s_i & ~src_prev_q;
  assign fall = ~src_s_i & src_prev_q;

  always_comb begin
    unique case (kind)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      default:   hit_o = 1'b0;
    endcase
  end

  assign pause_o = (gate_s_i == pause_pol_i);

  // R2 / R3: a synchronized level makes a detected edge last one cycle only
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !hit_o);
endmodule

// File: rtl/gec_core.sv
module gec_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic             hit_i,
  input  logic             pause_i,
  output logic             bump_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  assign bump_o     = armed_q & hit_i & ~pause_i & ~clear_i;
  assign cnt_next_o = cnt_q + 1'b1;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (clear_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (start_i) armed_q <= 1'b1;
      if (bump_o)  cnt_q   <= cnt_next_o;
    end
  end

  // R5: a pause freezes the count
  a_r5_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_i && !clear_i) |=> cnt_q == $past(cnt_q));
  // R4: nothing counts while disarmed
  a_r4_idle_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !clear_i) |=> cnt_q == $past(cnt_q));
  // R9: clear zeroes and disarms
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0) && !armed_q);
  // R8: wrap from all ones to zero
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && armed_q && !pause_i && !clear_i && cnt_q == CNT_MAX) |=> cnt_q == '0);
endmodule

// File: rtl/gec_stream.sv
module gec_stream #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             bump_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cnt_next_i,
  output logic [CNT_W-1:0] out_data_o,
  output logic             out_valid_o,
  input  logic             out_ready_i
);
  logic             valid_q, pend_q;
  logic [CNT_W-1:0] data_q;
  logic             slot_free;

  assign slot_free = ~valid_q | out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      data_q  <= '0;
    end else if (clear_i) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      data_q  <= '0;
    end else if (slot_free && bump_i) begin
      data_q  <= cnt_next_i;
      valid_q <= 1'b1;
      pend_q  <= 1'b0;
    end else if (slot_free && pend_q) begin
      data_q  <= cnt_i;
      valid_q <= 1'b1;
      pend_q  <= 1'b0;
    end else if (bump_i) begin
      pend_q  <= 1'b1;
    end else if (valid_q && out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign out_data_o  = data_q;
  assign out_valid_o = valid_q;

  // R7: a stalled beat stays put
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready_i && !clear_i) |=> valid_q && (data_q == $past(data_q)));
  // R6: a counted edge with a free slot becomes a beat
  a_r6_beat_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (bump_i && slot_free && !clear_i) |=> valid_q && (data_q == $past(cnt_next_i)));
endmodule

// File: rtl/gated_edge_counter.sv
module gated_edge_counter
  import gec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic             edge_sel_i,
  input  logic             pause_pol_i,
  input  logic             src_i,
  input  logic             gate_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] out_data_o,
  output logic             out_valid_o,
  input  logic             out_ready_i
);
  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] async_in, sync_out;
  logic              hit, pause, bump;
  logic [CNT_W-1:0]  cnt, cnt_next;

  assign async_in = {gate_i, src_i};

  gec_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(async_in), .q_o(sync_out)
  );

  gec_edge u_edge (
    .clk(clk), .rst_n(rst_n),
    .src_s_i(sync_out[0]), .gate_s_i(sync_out[1]),
    .edge_sel_i(edge_sel_i), .pause_pol_i(pause_pol_i),
    .hit_o(hit), .pause_o(pause)
  );

  gec_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .start_i(start_i),
    .hit_i(hit), .pause_i(pause), .bump_o(bump),
    .cnt_o(cnt), .cnt_next_o(cnt_next)
  );

  gec_stream #(.CNT_W(CNT_W)) u_stream (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .bump_i(bump),
    .cnt_i(cnt), .cnt_next_i(cnt_next),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i)
  );

  assign count_o = cnt;
endmodule

// File: tb/tb_gated_edge_counter.sv
module tb_gated_edge_counter;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_i = 0, start_i = 0, edge_sel_i = 0, pause_pol_i = 1;
  logic src_i = 0, gate_i = 0, out_ready_i = 1;
  logic [W-1:0] count_o, out_data_o;
  logic out_valid_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gated_edge_counter #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .start_i(start_i),
    .edge_sel_i(edge_sel_i), .pause_pol_i(pause_pol_i), .src_i(src_i),
    .gate_i(gate_i), .count_o(count_o), .out_data_o(out_data_o),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_src(int n);
    for (int i = 0; i < n; i++) begin
      src_i = ~src_i; cyc(4);
      src_i = ~src_i; cyc(4);
    end
  endtask

  task automatic do_start();
    start_i = 1; cyc(1); start_i = 0;
  endtask

  task automatic do_clear();
    clear_i = 1; cyc(1); clear_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 count", count_o, 0);
    chk("R1 valid", out_valid_o, 0);
  endtask

  task automatic t_unarmed();
    int seen = 0;
    src_i = 1;
    for (int i = 0; i < 6; i++) begin cyc(1); seen |= out_valid_o; end
    src_i = 0; cyc(4);
    chk("R4 no count before start", count_o, 0);
    chk("R4 no beat before start", seen, 0);
  endtask

  task automatic t_latency();
    do_start();
    src_i = 1;
    cyc(1); chk("R10 after 1 edge", count_o, 0);
    cyc(1); chk("R10 after 2 edges", count_o, 0);
    cyc(1); chk("R10 after 3 edges", count_o, 1);
    chk("R6 beat valid", out_valid_o, 1);
    chk("R6 beat data", out_data_o, 1);
    cyc(1); chk("R7 accepted beat drops", out_valid_o, 0);
    src_i = 0; cyc(4);
    chk("R2 falling edge ignored in rise mode", count_o, 1);
  endtask

  task automatic t_rising();
    pulse_src(3);
    chk("R2 three rising edges", count_o, 4);
  endtask

  task automatic t_pause();
    int seen = 0;
    pause_pol_i = 1; gate_i = 1; cyc(4);
    for (int i = 0; i < 2; i++) begin
      src_i = 1;
      for (int k = 0; k < 4; k++) begin cyc(1); seen |= out_valid_o; end
      src_i = 0;
      for (int k = 0; k < 4; k++) begin cyc(1); seen |= out_valid_o; end
    end
    chk("R5 pause high holds", count_o, 4);
    chk("R5 no beat while paused", seen, 0);
    pause_pol_i = 0; cyc(1);
    pulse_src(1);
    chk("R5 gate high not pausing with pol 0", count_o, 5);
    gate_i = 0; cyc(4);
    pulse_src(1);
    chk("R5 pause low holds", count_o, 5);
    pause_pol_i = 1; cyc(4);
  endtask

  task automatic t_falling();
    edge_sel_i = 1; cyc(1);
    src_i = 1; cyc(4);
    chk("R3 rising ignored in fall mode", count_o, 5);
    src_i = 0; cyc(4);
    chk("R3 falling counted", count_o, 6);
    edge_sel_i = 0; cyc(1);
  endtask

  task automatic t_clear();
    do_clear();
    chk("R9 clear count", count_o, 0);
    chk("R9 clear valid", out_valid_o, 0);
    pulse_src(2);
    chk("R9 disarmed after clear", count_o, 0);
    clear_i = 1; start_i = 1; cyc(1); clear_i = 0; start_i = 0;
    pulse_src(1);
    chk("R9 clear beats start", count_o, 0);
  endtask

  task automatic t_backpressure();
    do_start();
    out_ready_i = 0;
    pulse_src(3);
    chk("R7 count runs on", count_o, 3);
    chk("R7 stalled valid", out_valid_o, 1);
    chk("R7 stalled data", out_data_o, 1);
    out_ready_i = 1; cyc(1);
    chk("R7 next beat valid", out_valid_o, 1);
    chk("R7 next beat latest", out_data_o, 3);
    cyc(1);
    chk("R7 drained", out_valid_o, 0);
  endtask

  task automatic t_wrap();
    do_clear(); do_start();
    pulse_src(15);
    chk("R8 at max", count_o, 15);
    pulse_src(1);
    chk("R8 wrapped", count_o, 0);
    chk("R8 wrapped beat data", out_data_o, 0);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    t_reset();
    t_unarmed();
    t_latency();
    t_rising();
    t_pause();
    t_falling();
    t_clear();
    t_backpressure();
    t_wrap();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule